// File: doc/BRIEF.md
# Halfband 2x Interpolation Filter

This block doubles the sample rate of one signed 10-bit channel. A new input sample is accepted at most every second clock cycle, and a filtered output sample leaves on every clock cycle. The filter is a fixed 43-tap symmetric halfband response. Every second coefficient away from the centre is zero, so the filter splits into two polyphase branches that each run at half the clock rate. One branch is the centre tap alone. The other is a 22-tap symmetric sum built with pre-adders. A phase toggle picks one branch per cycle, and the selected value is rounded, scaled by 2^-11 and clipped into a registered 10-bit output.

The upstream source pulses `in_valid` with each new sample. The pulse also realigns the phase toggle, so the cycle after an accepted sample always carries the pre-added branch. In steady streaming, `in_valid` is high on every second cycle.

Top module: `hbi_interp`

## Requirements
- R1: While `rst_n` is low at a rising edge, `out_data` becomes 0 at that edge. The same edge clears the 22-sample delay line and sets the phase to the pre-added branch. After release with no input, both phases produce 0.
- R2: The value `out_data` takes at a rising edge is computed from the delay line and phase as they stood just before that edge. An edge with `in_valid` high shifts `in_data` into the line. The next edge always outputs the pre-added branch of the updated line. After that the phase alternates every cycle until the next accepted sample.
- R3: The delay line holds s[0] (newest) through s[21]. On the centre phase, the output is round(1998*s[10]/2^11).
- R4: On the pre-added phase, the output is round(sum over j=0..10 of c[j]*(s[10-j]+s[11+j]))/2^11. The coefficients are c = +1264, -400, +216, -131, +81, -50, +29, -16, +8, -3, +1.
- R5: Any result above 511 is output as 511. Any result below -512 is output as -512.
- R6: Rounding adds 2^10 and then shifts arithmetically right by 11, so exact halves go toward plus infinity. A centre value of -499.5 gives -499, a pre-added value of +0.5 gives 1, and -0.5 gives 0.
- R7: While `in_valid` is low, the delay line does not change and `in_data` has no effect. The output keeps alternating between the centre and pre-added values of the same line.
- R8: With a constant input c filling the whole line, both phases give round(1998*c/2^11). For example, 400 gives 390 and -300 gives -293.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Full-rate clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Accept `in_data` at this edge and realign the phase |
| in_data | input | 10 | Signed input sample |
| out_data | output | 10 | Signed, registered, saturated output sample |

## Verification
Two functions can fall on the same rising edge: the shift of a new sample into the delay line, and the output of the centre branch. During full-rate streaming, `in_valid` lands exactly on the centre-phase edge. The bench provokes this by feeding samples back to back. It judges the result by requiring the centre value to come from the line before the shift, and the following pre-added value to come from the line after it. A second case moves a sample one cycle off the steady rhythm. There, the acceptance edge must emit the old pre-added value, and the next edge must emit the new one.

// File: rtl/hbi_pkg.sv
// Shared constants for the halfband interpolator.
// Assumes the fixed 43-tap coefficient set; nothing here is programmable.
package hbi_pkg;
    localparam int NUM_PAIRS   = 11;    // nonzero symmetric side-tap pairs
    localparam int CENTER_COEF = 1998;  // centre tap weight
    localparam int FRAC_BITS   = 11;    // output scaling shift

    // Signed side-tap weight, j = 0 is the pair next to the centre.
    function automatic int side_coef(input int j);
        case (j)
            0:       return 1264;
            1:       return -400;
            2:       return 216;
            3:       return -131;
            4:       return 81;
            5:       return -50;
            6:       return 29;
            7:       return -16;
            8:       return 8;
            9:       return -3;
            10:      return 1;
            default: return 0;
        endcase
    endfunction
endpackage

// File: rtl/hbi_delay_line.sv
// Half-rate sample history for the interpolator.
// Shifts one sample in when shift_en is high; taps_o[0] is the newest.
// Assumes shift_en is pulsed at most once per output pair.
module hbi_delay_line #(
    parameter int DATA_W = 10,
    parameter int LEN    = 22
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     shift_en,
    input  logic signed [DATA_W-1:0] din,
    output logic signed [DATA_W-1:0] taps_o [LEN]
);
    // Shift register with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < LEN; k++) taps_o[k] <= '0;
        end else if (shift_en) begin
            taps_o[0] <= din;
            for (int k = 1; k < LEN; k++) taps_o[k] <= taps_o[k-1];
        end
    end

    // R7: idle cycles leave the history untouched
    a_r7_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> ($stable(taps_o[0]) && $stable(taps_o[LEN-1])));

    // R1: reset empties the history
    a_r1_line_cleared: assert property (@(posedge clk)
        !rst_n |=> (taps_o[0] == '0 && taps_o[LEN-1] == '0));
endmodule

// File: rtl/hbi_side_branch.sv
// Pre-added polyphase branch: pairs symmetric taps, weights each pair
// by its fixed coefficient and sums the products combinationally.
// Assumes ACC_W is wide enough for the full-scale sum without wrap.
module hbi_side_branch
    import hbi_pkg::*;
#(
    parameter int DATA_W = 10,
    parameter int ACC_W  = 26,
    parameter int PAIRS  = NUM_PAIRS
) (
    input  logic signed [DATA_W-1:0] taps_i [2*PAIRS],
    output logic signed [ACC_W-1:0]  sum_o
);
    logic signed [ACC_W-1:0] prod [PAIRS];

    for (genvar j = 0; j < PAIRS; j++) begin : g_pair
        localparam logic signed [ACC_W-1:0] K = ACC_W'(side_coef(j));
        logic signed [DATA_W:0] pre;
        // Pre-adder for the two taps sharing one weight.
        assign pre = {taps_i[PAIRS-1-j][DATA_W-1], taps_i[PAIRS-1-j]}
                   + {taps_i[PAIRS+j][DATA_W-1], taps_i[PAIRS+j]};
        // Constant weighting of the paired sum.
        assign prod[j] = ACC_W'(pre) * K;
    end

    // Sum of all weighted pairs.
    always_comb begin
        logic signed [ACC_W-1:0] acc;
        acc = '0;
        for (int j = 0; j < PAIRS; j++) acc = acc + prod[j];
        sum_o = acc;
    end
endmodule

// File: rtl/hbi_round_sat.sv
// Output stage: rounds half toward plus infinity, drops FRAC fraction
// bits, clips into the signed DATA_W range and registers the result.
module hbi_round_sat #(
    parameter int ACC_W  = 26,
    parameter int DATA_W = 10,
    parameter int FRAC   = 11
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic signed [ACC_W-1:0]  value_i,
    output logic signed [DATA_W-1:0] q_o
);
    localparam logic signed [ACC_W-1:0]  HALF = ACC_W'(1) <<< (FRAC - 1);
    localparam int MAXV = 2 ** (DATA_W - 1) - 1;
    localparam int MINV = -(2 ** (DATA_W - 1));
    localparam logic signed [ACC_W-1:0]  HI   = ACC_W'(MAXV);
    localparam logic signed [ACC_W-1:0]  LO   = ACC_W'(MINV);
    localparam logic signed [DATA_W-1:0] QMAX = DATA_W'(MAXV);
    localparam logic signed [DATA_W-1:0] QMIN = DATA_W'(MINV);

    logic signed [ACC_W-1:0]  rounded;
    logic signed [DATA_W-1:0] q_nxt;

    // Round and rescale.
    always_comb rounded = (value_i + HALF) >>> FRAC;

    // Clip into the output range.
    always_comb begin
        if (rounded > HI)      q_nxt = QMAX;
        else if (rounded < LO) q_nxt = QMIN;
        else                   q_nxt = rounded[DATA_W-1:0];
    end

    // Output register.
    always_ff @(posedge clk) begin
        if (!rst_n) q_o <= '0;
        else        q_o <= q_nxt;
    end

    // R5: overflow clips to the positive limit
    a_r5_clip_high: assert property (@(posedge clk) disable iff (!rst_n)
        (rounded > HI) |=> (q_o == QMAX));
    // R5: underflow clips to the negative limit
    a_r5_clip_low: assert property (@(posedge clk) disable iff (!rst_n)
        (rounded < LO) |=> (q_o == QMIN));
    // R1: reset drives the output to zero
    a_r1_reset_zero: assert property (@(posedge clk)
        !rst_n |=> (q_o == '0));
endmodule

// File: rtl/hbi_interp.sv
// Halfband 2x interpolator, top level.
// Holds the half-rate history, builds the centre and pre-added branches,
// alternates them with a phase toggle and emits one sample per cycle.
// Assumes in_valid is high at most every second cycle in normal use.
module hbi_interp
    import hbi_pkg::*;
#(
    parameter int DATA_W = 10,
    parameter int ACC_W  = DATA_W + 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic signed [DATA_W-1:0] in_data,
    output logic signed [DATA_W-1:0] out_data
);
    localparam int LINE_LEN = 2 * NUM_PAIRS;
    localparam int CTR_IDX  = NUM_PAIRS - 1;
    localparam int CTR_LIM  = (CENTER_COEF * (2 ** (DATA_W - 1))) / (2 ** FRAC_BITS);

    logic signed [DATA_W-1:0] line_taps [LINE_LEN];
    logic signed [ACC_W-1:0]  side_val;
    logic signed [ACC_W-1:0]  ctr_val;
    logic signed [ACC_W-1:0]  sel_val;
    logic                     ph;        // 1 = centre branch this cycle
    logic                     line_zero;

    hbi_delay_line #(.DATA_W(DATA_W), .LEN(LINE_LEN)) u_line (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (in_valid),
        .din      (in_data),
        .taps_o   (line_taps)
    );

    hbi_side_branch #(.DATA_W(DATA_W), .ACC_W(ACC_W), .PAIRS(NUM_PAIRS)) u_side (
        .taps_i (line_taps),
        .sum_o  (side_val)
    );

    // Centre branch: one weighted tap from the middle of the history.
    assign ctr_val = ACC_W'(line_taps[CTR_IDX]) * ACC_W'(CENTER_COEF);

    // Phase toggle, realigned by each accepted sample.
    always_ff @(posedge clk) begin
        if (!rst_n)        ph <= 1'b0;
        else if (in_valid) ph <= 1'b0;
        else               ph <= ~ph;
    end

    // Branch select.
    always_comb sel_val = ph ? ctr_val : side_val;

    // Detect an all-zero history.
    always_comb begin
        line_zero = 1'b1;
        for (int k = 0; k < LINE_LEN; k++)
            if (line_taps[k] != '0) line_zero = 1'b0;
    end

    hbi_round_sat #(.ACC_W(ACC_W), .DATA_W(DATA_W), .FRAC(FRAC_BITS)) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .value_i (sel_val),
        .q_o     (out_data)
    );

    // R2: the edge after an accepted sample selects the pre-added branch
    a_r2_side_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (sel_val == side_val));
    // R3: a centre-phase output never exceeds the scaled centre limit
    a_r3_center_bound: assert property (@(posedge clk) disable iff (!rst_n)
        ph |=> (out_data <= CTR_LIM && out_data >= -CTR_LIM));
    // R8: an empty history yields a zero output in either phase
    a_r8_quiet_line: assert property (@(posedge clk) disable iff (!rst_n)
        line_zero |=> (out_data == '0));
endmodule

// File: tb/hbi_interp_bench.sv
`timescale 1ns/1ps
module hbi_interp_bench;
    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic signed [9:0] in_data = '0;
    logic signed [9:0] out_data;

    int total = 0;
    int bad   = 0;
    int mline [22];

    localparam int KMAG [11] = '{1264, 400, 216, 131, 81, 50, 29, 16, 8, 3, 1};
    localparam int NVEC = 23;
    // Impulse table: input, expected centre of previous line, expected side of new line.
    localparam int VEC_IN   [NVEC] = '{511, 0,0,0,0,0,0,0,0,0,0,0,0,0,0,0,0,0,0,0,0,0,0};
    localparam int VEC_CTR  [NVEC] = '{0,0,0,0,0,0,0,0,0,0,0,499,0,0,0,0,0,0,0,0,0,0,0};
    localparam int VEC_SIDE [NVEC] = '{0,-1,2,-4,7,-12,20,-33,54,-100,315,
                                       315,-100,54,-33,20,-12,7,-4,2,-1,0,0};

    hbi_interp u_hbi_interp (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_data  (in_data),
        .out_data (out_data)
    );

    always #2.5 clk = ~clk;

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: run hung, actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    task automatic check(input string tag, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, got, exp);
        end
    endtask

    function automatic int rs(input int v);
        int r;
        r = (v + 1024) >>> 11;
        if (r > 511)  r = 511;
        if (r < -512) r = -512;
        return r;
    endfunction

    function automatic int m_side();
        int acc = 0;
        for (int j = 0; j < 11; j++)
            acc += ((j % 2 == 0) ? KMAG[j] : -KMAG[j]) * (mline[10-j] + mline[11+j]);
        return rs(acc);
    endfunction

    function automatic int m_ctr();
        return rs(1998 * mline[10]);
    endfunction

    function automatic bit pos_tap(input int k);
        int j;
        j = (k <= 10) ? 10 - k : k - 11;
        return (j % 2 == 0);
    endfunction

    // Called at a falling edge; feeds one sample at full streaming rate.
    task automatic feed(input int x, output int c_prev, output int s_now);
        in_valid = 1'b1;
        in_data  = x[9:0];
        @(negedge clk);
        c_prev   = out_data;
        in_valid = 1'b0;
        for (int k = 21; k > 0; k--) mline[k] = mline[k-1];
        mline[0] = x;
        @(negedge clk);
        s_now = out_data;
    endtask

    task automatic clear_line();
        int c, s;
        for (int i = 0; i < 22; i++) feed(0, c, s);
    endtask

    initial begin
        int c, s, ec, es, lfsr;
        for (int k = 0; k < 22; k++) mline[k] = 0;
        repeat (3) @(negedge clk);
        check("R1 reset output", out_data, 0);
        rst_n = 1'b1;
        @(negedge clk); check("R1 idle after reset a", out_data, 0);
        @(negedge clk); check("R1 idle after reset b", out_data, 0);

        // Table walk: impulse response, R3 and R4.
        for (int n = 0; n < NVEC; n++) begin
            feed(VEC_IN[n], c, s);
            check("R3 impulse centre", c, VEC_CTR[n]);
            check("R4 impulse side", s, VEC_SIDE[n]);
        end

        // Pseudo-random stream against the bench model, R3 and R4.
        lfsr = 32'h1ACE;
        for (int n = 0; n < 30; n++) begin
            lfsr = (lfsr * 1103515245 + 12345) & 32'h7fffffff;
            ec = m_ctr();
            feed(((lfsr >> 8) % 1024) - 512, c, s);
            check("R3 stream centre", c, ec);
            check("R4 stream side", s, m_side());
        end

        // R7: idle with changing in_data; line held, phases alternate.
        in_data = -77;
        @(negedge clk); check("R7 hold centre", out_data, m_ctr());
        in_data = 200;
        @(negedge clk); check("R7 hold side", out_data, m_side());
        @(negedge clk); check("R7 hold centre again", out_data, m_ctr());
        @(negedge clk); check("R7 hold side again", out_data, m_side());
        @(negedge clk); check("R7 hold centre third", out_data, m_ctr());

        // R2: sample arrives one cycle off rhythm.
        es = m_side();
        feed(123, c, s);
        check("R2 off-phase accept edge", c, es);
        check("R2 side after accept", s, m_side());

        // R5: saturation both ways.
        for (int i = 0; i < 22; i++) feed(pos_tap(21 - i) ? 511 : -512, c, s);
        check("R5 clip high", s, 511);
        for (int i = 0; i < 22; i++) feed(pos_tap(21 - i) ? -512 : 511, c, s);
        check("R5 clip low", s, -512);

        // R6: rounding of exact halves.
        clear_line();
        feed(128, c, s); feed(0, c, s); feed(0, c, s);
        check("R6 plus half rounds up", s, 1);
        clear_line();
        feed(-128, c, s); feed(0, c, s); feed(0, c, s);
        check("R6 minus half rounds to zero", s, 0);
        clear_line();
        feed(-512, c, s);
        for (int i = 0; i < 10; i++) feed(0, c, s);
        check("R6 exact side value", s, -316);
        feed(0, c, s);
        check("R6 centre half rounds up", c, -499);

        // R8: DC gain.
        for (int i = 0; i < 22; i++) feed(400, c, s);
        check("R8 dc side positive", s, 390);
        feed(400, c, s);
        check("R8 dc centre positive", c, 390);
        for (int i = 0; i < 22; i++) feed(-300, c, s);
        check("R8 dc side negative", s, -293);
        feed(-300, c, s);
        check("R8 dc centre negative", c, -293);

        // R1: reset mid-stream with a full line clears everything.
        rst_n = 1'b0;
        @(negedge clk); check("R1 reset mid-stream", out_data, 0);
        rst_n = 1'b1;
        for (int k = 0; k < 22; k++) mline[k] = 0;
        @(negedge clk); check("R1 cleared line a", out_data, 0);
        @(negedge clk); check("R1 cleared line b", out_data, 0);
        feed(0, c, s);
        check("R1 cleared centre", c, 0);
        check("R1 cleared side", s, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule